// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps the current window pointer and the window invalid mask for a windowed register file whose number of windows is a parameter. It takes one command per cycle: move down one window, move up one window, return from trap, or load the processor status word. For each command it works out the neighbouring window with wrap-around, looks that window up in the invalid mask and either commits the move or raises a trap request. The same logic assembles the 32-bit status word from its fields and breaks a written word back into those fields.

The register file and interrupt arbitration sit outside. The controller only drives the pointer that selects the active window, the status fields and a one-cycle trap request with a two-bit cause code. The invalid mask has its own write port, and the current mask value is available as an output.

Top module: `winptr_ctrl`

## Requirements
- R1: After reset the window pointer is 0, the invalid mask is all zeros and no trap is requested. The status word then has the supervisor bit set and all other writable fields cleared.
- R2: A save command (cmd_op 0) sets the pointer to its current value minus one. A save from window 0 goes to window NWIN-1.
- R3: A restore command (cmd_op 1) sets the pointer to its current value plus one. A restore from window NWIN-1 goes to window 0.
- R4: A save whose target window has its mask bit set raises trap code 1 (overflow). A restore whose target window has its mask bit set raises trap code 2 (underflow). In both cases the pointer stays where it was.
- R5: A return-from-trap command (cmd_op 2) issued while trap-enable is 1 raises trap code 3 (illegal) and changes no state.
- R6: A return-from-trap issued while trap-enable is 0 always sets trap-enable to 1. If the next window up is free, the pointer moves to it and the supervisor bit takes the value of the previous-supervisor bit. If that window is marked invalid, the command raises trap code 2 and leaves both the pointer and the supervisor bit unchanged.
- R7: A status write (cmd_op 3) whose bits 4:0 hold NWIN or more raises trap code 3 and changes no state.
- R8: A legal status write loads the fields from these bits: condition codes from 23:20, FPU-enable from 12, interrupt level from 11:8, supervisor from 7, previous supervisor from 6, trap-enable from 5, and the pointer from 4:0. All other bits are ignored.
- R9: The status word output places the fields at the same positions as R8, holds the VERSION constant in bits 31:24, and reads zero in bits 19:13.
- R10: A trap request is a one-cycle pulse on trap_valid that appears in the cycle after the offending command. Whenever trap_valid is low, trap_code is 0.
- R11: A mask write replaces the mask, and the new value appears on wim_o in the following cycle. A command issued in the same cycle as a mask write is checked against the old mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command: 0 save, 1 restore, 2 return-from-trap, 3 status write |
| cmd_wdata | input | 32 | Status word value for a status write |
| wim_we | input | 1 | Invalid mask write enable |
| wim_wdata | input | NWIN | New invalid mask |
| cwp | output | 5 | Current window pointer |
| psr_word | output | 32 | Packed status word |
| wim_o | output | NWIN | Current invalid mask |
| trap_valid | output | 1 | One-cycle trap request |
| trap_code | output | 2 | Trap cause: 1 overflow, 2 underflow, 3 illegal |

## Verification
Saves and restores are run across the wrap point in both directions, on a power-of-two window count and on a count of five. This separates the truncating variant of the pointer arithmetic from the comparing variant. Each mask-hit case is run next to a case with a clear mask, so a wrong bit lookup or a wrong neighbour shows up as a trap that is missing or one that should not be there. Return-from-trap is run in three setups: trap-enable already set, a free target window, and an invalid target window. These three tell the illegal path apart from a move-with-copy and from an underflow that still sets trap-enable. Status writes carry junk in the ignored bits and pointer values just past the legal range, which checks the field positions and the range limit.

// File: rtl/winptr_pkg.sv
package winptr_pkg;

   localparam int CWP_W = 5;
   localparam int ICC_W = 4;
   localparam int PIL_W = 4;

   typedef enum logic [1:0] {
      OP_SAVE    = 2'd0,
      OP_RESTORE = 2'd1,
      OP_RETT    = 2'd2,
      OP_WRPSR   = 2'd3
   } win_op_e;

   typedef enum logic [1:0] {
      TRAP_NONE    = 2'd0,
      TRAP_WOVF    = 2'd1,
      TRAP_WUNF    = 2'd2,
      TRAP_ILLEGAL = 2'd3
   } trap_e;

   typedef struct packed {
      logic [ICC_W-1:0] icc;
      logic             ef;
      logic [PIL_W-1:0] pil;
      logic             sup;
      logic             psup;
      logic             et;
   } psr_flags_t;

   function automatic psr_flags_t psr_unpack(input logic [31:0] w);
      psr_flags_t f;
      f.icc  = w[23:20];
      f.ef   = w[12];
      f.pil  = w[11:8];
      f.sup  = w[7];
      f.psup = w[6];
      f.et   = w[5];
      return f;
   endfunction

endpackage

// File: rtl/winptr_step.sv
module winptr_step #(
   parameter int NWIN = 8
) (
   input  logic [winptr_pkg::CWP_W-1:0] cur,
   output logic [winptr_pkg::CWP_W-1:0] nxt_inc,
   output logic [winptr_pkg::CWP_W-1:0] nxt_dec
);
   localparam int CW   = winptr_pkg::CWP_W;
   localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);
   localparam int LW   = (NWIN > 1) ? $clog2(NWIN) : 1;

   generate
      if (POW2) begin : g_pow2
         // wrap falls out of truncation to log2(NWIN) bits
         logic [LW-1:0] lo, lo_inc, lo_dec;
         assign lo     = cur[LW-1:0];
         assign lo_inc = lo + 1'b1;
         assign lo_dec = lo - 1'b1;
         assign nxt_inc = CW'(lo_inc);
         assign nxt_dec = CW'(lo_dec);
      end else begin : g_cmp
         localparam logic [CW-1:0] LAST = CW'(NWIN - 1);
         assign nxt_inc = (cur == LAST) ? '0 : cur + 1'b1;
         assign nxt_dec = (cur == '0) ? LAST : cur - 1'b1;
      end
   endgenerate
endmodule

// File: rtl/winptr_mask_pick.sv
module winptr_mask_pick #(
   parameter int NWIN = 8
) (
   input  logic [NWIN-1:0]              mask,
   input  logic [winptr_pkg::CWP_W-1:0] idx,
   output logic                         hit
);
   localparam int CW = winptr_pkg::CWP_W;
   logic [NWIN-1:0] sel;

   genvar i;
   generate
      for (i = 0; i < NWIN; i++) begin : g_dec
         assign sel[i] = (idx == CW'(i));
      end
   endgenerate

   assign hit = |(sel & mask);
endmodule

// File: rtl/winptr_psr_pack.sv
module winptr_psr_pack #(
   parameter logic [7:0] VERSION = 8'h35
) (
   input  winptr_pkg::psr_flags_t         flags,
   input  logic [winptr_pkg::CWP_W-1:0]   cwp,
   output logic [31:0]                    word
);
   assign word = {VERSION, flags.icc, 7'b0, flags.ef, flags.pil,
                  flags.sup, flags.psup, flags.et, cwp};
endmodule

// File: rtl/winptr_ctrl.sv
module winptr_ctrl #(
   parameter int         NWIN    = 8,
   parameter logic [7:0] VERSION = 8'h35
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic [1:0]      cmd_op,
   input  logic [31:0]     cmd_wdata,
   input  logic            wim_we,
   input  logic [NWIN-1:0] wim_wdata,
   output logic [4:0]      cwp,
   output logic [31:0]     psr_word,
   output logic [NWIN-1:0] wim_o,
   output logic            trap_valid,
   output logic [1:0]      trap_code
);
   import winptr_pkg::*;

   localparam int CW = CWP_W;

   generate
      if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
         $error("winptr_ctrl: NWIN must lie in 2..32");
      end
   endgenerate

   logic [CW-1:0]   cwp_q, cwp_n;
   psr_flags_t      flg_q, flg_n;
   logic [NWIN-1:0] wim_q;
   logic            trap_v_q;
   trap_e           trap_c_q, trap_n;
   logic            past_ok;

   logic [CW-1:0]   up_cwp, dn_cwp;
   logic            up_bad, dn_bad;
   logic            wr_range_bad;
   win_op_e         op;

   assign op = win_op_e'(cmd_op);

   winptr_step #(.NWIN(NWIN)) u_step (
      .cur     (cwp_q),
      .nxt_inc (up_cwp),
      .nxt_dec (dn_cwp)
   );

   winptr_mask_pick #(.NWIN(NWIN)) u_pick_up (
      .mask (wim_q),
      .idx  (up_cwp),
      .hit  (up_bad)
   );

   winptr_mask_pick #(.NWIN(NWIN)) u_pick_dn (
      .mask (wim_q),
      .idx  (dn_cwp),
      .hit  (dn_bad)
   );

   assign wr_range_bad = ({1'b0, cmd_wdata[CW-1:0]} >= (CW+1)'(NWIN));

   always_comb begin
      cwp_n  = cwp_q;
      flg_n  = flg_q;
      trap_n = TRAP_NONE;
      if (cmd_valid) begin
         unique case (op)
            OP_SAVE: begin
               if (dn_bad) trap_n = TRAP_WOVF;
               else        cwp_n  = dn_cwp;
            end
            OP_RESTORE: begin
               if (up_bad) trap_n = TRAP_WUNF;
               else        cwp_n  = up_cwp;
            end
            OP_RETT: begin
               if (flg_q.et) begin
                  trap_n = TRAP_ILLEGAL;
               end else begin
                  flg_n.et = 1'b1;
                  if (up_bad) begin
                     trap_n = TRAP_WUNF;
                  end else begin
                     cwp_n     = up_cwp;
                     flg_n.sup = flg_q.psup;
                  end
               end
            end
            OP_WRPSR: begin
               if (wr_range_bad) begin
                  trap_n = TRAP_ILLEGAL;
               end else begin
                  flg_n = psr_unpack(cmd_wdata);
                  cwp_n = cmd_wdata[CW-1:0];
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cwp_q    <= '0;
         flg_q    <= '{icc: '0, ef: 1'b0, pil: '0, sup: 1'b1, psup: 1'b0, et: 1'b0};
         wim_q    <= '0;
         trap_v_q <= 1'b0;
         trap_c_q <= TRAP_NONE;
         past_ok  <= 1'b0;
      end else begin
         cwp_q    <= cwp_n;
         flg_q    <= flg_n;
         if (wim_we) wim_q <= wim_wdata;
         trap_v_q <= (trap_n != TRAP_NONE);
         trap_c_q <= trap_n;
         past_ok  <= 1'b1;
      end
   end

   winptr_psr_pack #(.VERSION(VERSION)) u_pack (
      .flags (flg_q),
      .cwp   (cwp_q),
      .word  (psr_word)
   );

   assign cwp        = cwp_q;
   assign wim_o      = wim_q;
   assign trap_valid = trap_v_q;
   assign trap_code  = trap_c_q;

   AST_CWP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (cwp < CW'(NWIN))) else $error("cwp out of range"); // R7

   AST_TRAP_KEEPS_CWP: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && trap_valid) |-> (cwp == $past(cwp))) else $error("cwp moved on trap"); // R4

   AST_TRAP_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && trap_valid) |-> $past(cmd_valid)) else $error("trap without command"); // R10

   AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid |-> (trap_code == 2'd0)) else $error("stale trap code"); // R10

   AST_RETT_SETS_ET: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(cmd_valid && cmd_op == 2'd2)) |-> psr_word[5]) else $error("et not set"); // R6

   AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (psr_word[31:24] == VERSION && psr_word[19:13] == 7'b0)) else $error("fixed bits"); // R9

endmodule

// File: tb/sim_winptr_ctrl.sv
`timescale 1ns/1ps
module sim_winptr_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        v0 = 1'b0, v1 = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [31:0] wd = 32'd0;
   logic        wim_we = 1'b0;
   logic [7:0]  wim_wd = 8'd0;

   logic [4:0]  cwp0, cwp1;
   logic [31:0] psr0, psr1;
   logic [7:0]  wim0;
   logic [4:0]  wim1;
   logic        tv0, tv1;
   logic [1:0]  tc0, tc1;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   winptr_ctrl #(.NWIN(8)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(v0), .cmd_op(op), .cmd_wdata(wd),
      .wim_we(wim_we), .wim_wdata(wim_wd),
      .cwp(cwp0), .psr_word(psr0), .wim_o(wim0), .trap_valid(tv0), .trap_code(tc0)
   );

   winptr_ctrl #(.NWIN(5)) u1 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(v1), .cmd_op(op), .cmd_wdata(wd),
      .wim_we(1'b0), .wim_wdata(5'd0),
      .cwp(cwp1), .psr_word(psr1), .wim_o(wim1), .trap_valid(tv1), .trap_code(tc1)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic cmd0(input logic [1:0] o, input logic [31:0] d);
      @(negedge clk);
      op = o; wd = d; v0 = 1'b1;
      @(posedge clk); #1;
      v0 = 1'b0;
   endtask

   task automatic cmd1(input logic [1:0] o, input logic [31:0] d);
      @(negedge clk);
      op = o; wd = d; v1 = 1'b1;
      @(posedge clk); #1;
      v1 = 1'b0;
   endtask

   task automatic set_mask(input logic [7:0] m);
      @(negedge clk);
      wim_we = 1'b1; wim_wd = m;
      @(posedge clk); #1;
      wim_we = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 cwp", {27'd0, cwp0}, 32'd0);
      chk("R1 psr", psr0, 32'h3500_0080);
      chk("R1 wim", {24'd0, wim0}, 32'd0);
      chk("R1 trap", {30'd0, tv0, 1'b0}, 32'd0);
   endtask

   task automatic t_save;
      cmd0(2'd0, 0);
      chk("R2 wrap 0->7", {27'd0, cwp0}, 32'd7);
      chk("R2 no trap", {31'd0, tv0}, 32'd0);
      cmd0(2'd0, 0);
      chk("R2 7->6", {27'd0, cwp0}, 32'd6);
   endtask

   task automatic t_restore;
      cmd0(2'd1, 0);
      chk("R3 6->7", {27'd0, cwp0}, 32'd7);
      cmd0(2'd1, 0);
      chk("R3 wrap 7->0", {27'd0, cwp0}, 32'd0);
   endtask

   task automatic t_overflow;
      set_mask(8'h80);
      chk("R11 readback", {24'd0, wim0}, 32'h80);
      cmd0(2'd0, 0);
      chk("R4 ovf valid", {31'd0, tv0}, 32'd1);
      chk("R4 ovf code", {30'd0, tc0}, 32'd1);
      chk("R4 ovf cwp", {27'd0, cwp0}, 32'd0);
      @(posedge clk); #1;
      chk("R10 pulse end", {31'd0, tv0}, 32'd0);
      chk("R10 code idle", {30'd0, tc0}, 32'd0);
      // mask cleared in the same cycle as a save: old mask applies
      @(negedge clk);
      wim_we = 1'b1; wim_wd = 8'h00; op = 2'd0; v0 = 1'b1;
      @(posedge clk); #1;
      wim_we = 1'b0; v0 = 1'b0;
      chk("R11 old mask used", {30'd0, tc0}, 32'd1);
      chk("R11 new mask", {24'd0, wim0}, 32'd0);
      chk("R11 cwp held", {27'd0, cwp0}, 32'd0);
   endtask

   task automatic t_underflow;
      cmd0(2'd3, 32'h0000_0086);
      chk("R8 cwp6", psr0, 32'h3500_0086);
      set_mask(8'h80);
      cmd0(2'd1, 0);
      chk("R4 unf code", {30'd0, tc0}, 32'd2);
      chk("R4 unf cwp", {27'd0, cwp0}, 32'd6);
      set_mask(8'h00);
      cmd0(2'd1, 0);
      chk("R3 clear mask moves", {27'd0, cwp0}, 32'd7);
      chk("R3 no trap", {31'd0, tv0}, 32'd0);
   endtask

   task automatic t_wrpsr;
      cmd0(2'd3, 32'hC3AF_F563);
      chk("R8 fields", psr0, 32'h35A0_1563);
      chk("R9 cwp port", {27'd0, cwp0}, 32'd3);
      chk("R8 no trap", {31'd0, tv0}, 32'd0);
   endtask

   task automatic t_wrpsr_bad;
      cmd0(2'd3, 32'h0000_0008);
      chk("R7 code", {30'd0, tc0}, 32'd3);
      chk("R7 unchanged", psr0, 32'h35A0_1563);
      cmd0(2'd3, 32'h0000_001F);
      chk("R7 code 31", {30'd0, tc0}, 32'd3);
      chk("R7 unchanged 31", psr0, 32'h35A0_1563);
   endtask

   task automatic t_rett_illegal;
      cmd0(2'd2, 0);
      chk("R5 code", {30'd0, tc0}, 32'd3);
      chk("R5 unchanged", psr0, 32'h35A0_1563);
   endtask

   task automatic t_rett_ok;
      cmd0(2'd3, 32'h0000_0042);
      chk("R6 setup", psr0, 32'h3500_0042);
      cmd0(2'd2, 0);
      chk("R6 move copy", psr0, 32'h3500_00E3);
      chk("R6 no trap", {31'd0, tv0}, 32'd0);
   endtask

   task automatic t_rett_unf;
      cmd0(2'd3, 32'h0000_0042);
      set_mask(8'h08);
      cmd0(2'd2, 0);
      chk("R6 unf code", {30'd0, tc0}, 32'd2);
      chk("R6 unf state", psr0, 32'h3500_0062);
      set_mask(8'h00);
   endtask

   task automatic t_five;
      cmd1(2'd0, 0);
      chk("R2 n5 wrap 0->4", {27'd0, cwp1}, 32'd4);
      cmd1(2'd1, 0);
      chk("R3 n5 wrap 4->0", {27'd0, cwp1}, 32'd0);
      cmd1(2'd3, 32'h0000_0005);
      chk("R7 n5 code", {30'd0, tc1}, 32'd3);
      chk("R7 n5 cwp", {27'd0, cwp1}, 32'd0);
      cmd1(2'd3, 32'h0000_0004);
      chk("R8 n5 top legal", {27'd0, cwp1}, 32'd4);
      chk("R8 n5 no trap", {31'd0, tv1}, 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      t_reset;
      t_save;
      t_restore;
      t_overflow;
      t_underflow;
      t_wrpsr;
      t_wrpsr_bad;
      t_rett_illegal;
      t_rett_ok;
      t_rett_unf;
      t_five;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule